// File: doc/BRIEF.md
# Transmit Credit Availability Checker

This block sits beside an outbound packet scheduler and answers one question on every cycle: may the packet now waiting be sent? The credit status word that the link layer provides holds six credit fields, one header field and one data field for each of the three traffic classes (posted, non-posted, completion). The block captures that word in a register, unpacks it, and compares the credits the pending packet needs against the credits on offer for its class. A packet needs one header credit of its own class. A packet with a payload also needs one data credit for every started group of four dwords.

Two encodings need special handling. A field that is all ones means unlimited credit, so any request of that type passes. In a 3-bit field that same value of seven is also read as "seven or more". A mode input lowers the saturation point of the two non-posted fields to six. A system that hands out only one non-posted credit can pulse a completion-return input. Each pulse gives back one non-posted header credit, and that credit stays available until a non-posted packet is issued.

Top module: `tx_credit_gate`

## Requirements
- R1: After reset the registered credit word is zero and no completion credit is held, so `grant` is low for every request.
- R2: The credit word is decoded with fixed bit positions: posted header [2:0], posted data [14:3], non-posted header [17:15], non-posted data [20:18], completion header [23:21], completion data [35:24]. `grant` in a cycle depends on the word sampled at the preceding rising clock edge.
- R3: A packet needs one header credit of its class. A header field of zero blocks the grant unless R8 supplies the credit.
- R4: When `pkt_has_data` is 1 the data need is ceil(`pkt_len_dw`/4). It is granted when the need is at most the field value. When `pkt_has_data` is 0, or the need is zero, the data field of the class has no effect.
- R5: A 12-bit data field equal to 0xFFF satisfies any data need, including 256 credits.
- R6: A 3-bit field equal to 7 satisfies any need of its type. A non-posted data field of 7 passes a need of 16.
- R7: While `np_cap_mode` is 1, a non-posted header or data field of 6 satisfies any need. While it is 0, a value of 6 is compared normally.
- R8: A rising clock edge with `cpl_return` high makes one non-posted header credit available, even when the field reads zero. It is cleared at an edge where `pkt_issue` is high with class non-posted and `cpl_return` is low.
- R9: Class encoding is 0 posted, 1 non-posted, 2 completion. Code 3 never receives a grant.
- R10: Only the two fields of the requested class affect `grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| credit_word | input | 36 | Packed credit status, registered each cycle |
| np_cap_mode | input | 1 | Non-posted fields saturate at six |
| pkt_class | input | 2 | Class of the pending packet |
| pkt_has_data | input | 1 | Pending packet carries a payload |
| pkt_len_dw | input | 11 | Payload length in dwords (0 to 1024) |
| pkt_issue | input | 1 | Pending packet is being sent this cycle |
| cpl_return | input | 1 | A completion arrived; restore one non-posted header credit |
| grant | output | 1 | Pending packet may be sent |

## Verification
On every cycle the assertions check the following: the low grant right after reset, the refusal of the reserved class code, the blocking effect of a zero posted header field, and the passing effect of an unlimited posted data field and of saturated completion fields. They use their own registered copy of the word. Only the bench scenarios can show the ceiling-of-four data count at its edges and the different effect of the value six in the two modes. The same holds for the life cycle of the restored non-posted credit across completion and issue events, and for the isolation between classes.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int CREDIT_W = 36;
    localparam int HDR_W    = 3;
    localparam int DAT_W    = 12;
    localparam int NPD_W    = 3;
    localparam int LEN_W    = 11;
    localparam int NEED_W   = LEN_W - 1;
    localparam int NUM_CLS  = 3;

    typedef enum logic [1:0] {
        CLS_POSTED  = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL     = 2'd2,
        CLS_RSVD    = 2'd3
    } tcc_class_e;

    // MSB-first layout gives the bit positions the credit word uses
    typedef struct packed {
        logic [DAT_W-1:0] cpl_dat;
        logic [HDR_W-1:0] cpl_hdr;
        logic [NPD_W-1:0] np_dat;
        logic [HDR_W-1:0] np_hdr;
        logic [DAT_W-1:0] p_dat;
        logic [HDR_W-1:0] p_hdr;
    } tcc_credit_s;

    typedef struct packed {
        tcc_credit_s cred;
        logic        np_bonus;
    } tcc_state_s;
endpackage

// File: rtl/tcc_need_calc.sv
module tcc_need_calc
    import tcc_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int NW = NEED_W
) (
    input  logic          has_data,
    input  logic [LW-1:0] len_dw,
    output logic [NW-1:0] need
);
    logic [LW:0] rounded;

    always_comb begin
        rounded = {1'b0, len_dw} + (LW+1)'(3);
        need    = has_data ? NW'(rounded >> 2) : '0;
    end
endmodule

// File: rtl/tcc_field_ok.sv
module tcc_field_ok #(
    parameter int FW        = 3,
    parameter int NW        = 10,
    parameter bit CAPPABLE  = 1'b0,
    parameter int CAP_LEVEL = 6
) (
    input  logic [FW-1:0] avail,
    input  logic [NW-1:0] need,
    input  logic          cap_mode,
    output logic          ok
);
    localparam int XW = (FW > NW) ? FW : NW;

    logic [XW-1:0] avail_x;
    logic [XW-1:0] need_x;
    logic          unlimited;
    logic          capped;

    always_comb begin
        avail_x   = XW'(avail);
        need_x    = XW'(need);
        unlimited = &avail;
        capped    = CAPPABLE && cap_mode && (avail_x >= XW'(CAP_LEVEL));
        ok        = (need_x == '0) || unlimited || capped || (need_x <= avail_x);
    end
endmodule

// File: rtl/tx_credit_gate.sv
module tx_credit_gate
    import tcc_pkg::*;
#(
    parameter int CAP_LEVEL = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CREDIT_W-1:0] credit_word,
    input  logic                np_cap_mode,
    input  logic [1:0]          pkt_class,
    input  logic                pkt_has_data,
    input  logic [LEN_W-1:0]    pkt_len_dw,
    input  logic                pkt_issue,
    input  logic                cpl_return,
    output logic                grant
);
    tcc_state_s        state_d, state_q;
    logic [NEED_W-1:0] data_need;
    logic [HDR_W-1:0]  hdr_field [NUM_CLS];
    logic [NUM_CLS-1:0] hdr_ok;
    logic [NUM_CLS-1:0] dat_ok;

    // next-state logic
    always_comb begin
        state_d      = state_q;
        state_d.cred = tcc_credit_s'(credit_word);
        if (cpl_return) begin
            state_d.np_bonus = 1'b1;
        end else if (pkt_issue && (pkt_class == CLS_NONPOST)) begin
            state_d.np_bonus = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    tcc_need_calc u_need (
        .has_data (pkt_has_data),
        .len_dw   (pkt_len_dw),
        .need     (data_need)
    );

    // header fields; a returned completion stands in for an empty non-posted one
    always_comb begin
        hdr_field[CLS_POSTED]  = state_q.cred.p_hdr;
        hdr_field[CLS_NONPOST] = ((state_q.cred.np_hdr == '0) && state_q.np_bonus)
                                 ? HDR_W'(1) : state_q.cred.np_hdr;
        hdr_field[CLS_CPL]     = state_q.cred.cpl_hdr;
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        tcc_field_ok #(
            .FW        (HDR_W),
            .NW        (1),
            .CAPPABLE  (c == CLS_NONPOST),
            .CAP_LEVEL (CAP_LEVEL)
        ) u_hdr (
            .avail    (hdr_field[c]),
            .need     (1'b1),
            .cap_mode (np_cap_mode),
            .ok       (hdr_ok[c])
        );

        if (c == CLS_NONPOST) begin : g_narrow
            tcc_field_ok #(
                .FW        (NPD_W),
                .NW        (NEED_W),
                .CAPPABLE  (1'b1),
                .CAP_LEVEL (CAP_LEVEL)
            ) u_dat (
                .avail    (state_q.cred.np_dat),
                .need     (data_need),
                .cap_mode (np_cap_mode),
                .ok       (dat_ok[c])
            );
        end else begin : g_wide
            tcc_field_ok #(
                .FW        (DAT_W),
                .NW        (NEED_W),
                .CAPPABLE  (1'b0),
                .CAP_LEVEL (CAP_LEVEL)
            ) u_dat (
                .avail    ((c == CLS_POSTED) ? state_q.cred.p_dat : state_q.cred.cpl_dat),
                .need     (data_need),
                .cap_mode (np_cap_mode),
                .ok       (dat_ok[c])
            );
        end
    end

    always_comb begin
        unique case (pkt_class)
            CLS_POSTED:  grant = hdr_ok[CLS_POSTED]  && dat_ok[CLS_POSTED];
            CLS_NONPOST: grant = hdr_ok[CLS_NONPOST] && dat_ok[CLS_NONPOST];
            CLS_CPL:     grant = hdr_ok[CLS_CPL]     && dat_ok[CLS_CPL];
            default:     grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [35:0] credit_word,
    input logic [1:0]  pkt_class,
    input logic        pkt_has_data,
    input logic        grant
);
    logic [35:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= credit_word;
    end

    // R1
    reset_grant_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !grant);

    // R9
    rsvd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_class == 2'd3) |-> !grant);

    // R3
    posted_no_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_class == 2'd0 && seen_q[2:0] == 3'd0) |-> !grant);

    // R5
    posted_unlimited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_class == 2'd0 && seen_q[2:0] != 3'd0 && (&seen_q[14:3])) |-> grant);

    // R6
    cpl_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_class == 2'd2 && seen_q[23:21] == 3'd7 &&
         (!pkt_has_data || (&seen_q[35:24]))) |-> grant);
endmodule

bind tx_credit_gate tcc_checker u_tcc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .credit_word  (credit_word),
    .pkt_class    (pkt_class),
    .pkt_has_data (pkt_has_data),
    .grant        (grant)
);

// File: tb/tx_credit_gate_test.sv
`timescale 1ns/1ps
module tx_credit_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] credit_word = '0;
    logic        np_cap_mode = 1'b0;
    logic [1:0]  pkt_class = '0;
    logic        pkt_has_data = 1'b0;
    logic [10:0] pkt_len_dw = '0;
    logic        pkt_issue = 1'b0;
    logic        cpl_return = 1'b0;
    logic        grant;

    int checks = 0;
    int errors = 0;
    logic [35:0] m_word = '0;
    logic        m_bonus = 1'b0;

    always #10 clk = ~clk;

    tx_credit_gate uut (
        .clk(clk), .rst_n(rst_n), .credit_word(credit_word),
        .np_cap_mode(np_cap_mode), .pkt_class(pkt_class),
        .pkt_has_data(pkt_has_data), .pkt_len_dw(pkt_len_dw),
        .pkt_issue(pkt_issue), .cpl_return(cpl_return), .grant(grant)
    );

    function automatic logic [35:0] mk(input logic [2:0] ph, input logic [11:0] pd,
                                       input logic [2:0] nh, input logic [2:0] nd,
                                       input logic [2:0] ch, input logic [11:0] cd);
        return {cd, ch, nd, nh, pd, ph};
    endfunction

    function automatic logic expect_grant(input logic [35:0] w, input logic bonus,
                                          input logic cap, input logic [1:0] cls,
                                          input logic hasd, input logic [10:0] len);
        int need;
        int h;
        int d;
        logic hok;
        logic dok;
        need = hasd ? (int'(len) + 3) / 4 : 0;
        case (cls)
            2'd0: begin h = int'(w[2:0]);   d = int'(w[14:3]); end
            2'd1: begin h = int'(w[17:15]); d = int'(w[20:18]); end
            2'd2: begin h = int'(w[23:21]); d = int'(w[35:24]); end
            default: return 1'b0;
        endcase
        hok = (h != 0) || (cls == 2'd1 && bonus);
        if (need == 0) dok = 1'b1;
        else if (cls == 2'd1) dok = (d == 7) || (cap && d >= 6) || (need <= d);
        else dok = (d == 4095) || (need <= d);
        return hok && dok;
    endfunction

    task automatic step(input logic [35:0] w, input logic cap, input logic [1:0] cls,
                        input logic hasd, input logic [10:0] len,
                        input logic iss, input logic ret, input string tag);
        logic exp;
        @(negedge clk);
        credit_word = w; np_cap_mode = cap; pkt_class = cls;
        pkt_has_data = hasd; pkt_len_dw = len; pkt_issue = iss; cpl_return = ret;
        @(posedge clk);
        m_word = w;
        if (ret) m_bonus = 1'b1;
        else if (iss && cls == 2'd1) m_bonus = 1'b0;
        #5;
        exp = expect_grant(m_word, m_bonus, cap, cls, hasd, len);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s grant=%b expected=%b word=%h cls=%0d len=%0d",
                     tag, grant, exp, w, cls, len);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired grant=%b expected=done", grant);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (grant !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset grant=%b expected=0", grant);
        end
        rst_n = 1'b1;
        // R1: zero word after reset still refused
        step('0, 0, 2'd0, 0, 11'd0, 0, 0, "R1");
        // R2, R10: only posted header present
        step(mk(3'd1, 0, 0, 0, 0, 0), 0, 2'd0, 0, 0, 0, 0, "R2");
        step(mk(3'd1, 0, 0, 0, 0, 0), 0, 2'd1, 0, 0, 0, 0, "R10");
        step(mk(3'd1, 0, 0, 0, 0, 0), 0, 2'd2, 0, 0, 0, 0, "R10");
        step(mk(0, 0, 0, 0, 3'd2, 12'd5), 0, 2'd2, 1, 11'd20, 0, 0, "R2");
        // R3
        step(mk(0, 12'hFFF, 3'd7, 3'd7, 3'd7, 12'hFFF), 0, 2'd0, 0, 0, 0, 0, "R3");
        // R4: ceiling of length over four
        step(mk(3'd1, 12'd2, 0, 0, 0, 0), 0, 2'd0, 1, 11'd8, 0, 0, "R4");
        step(mk(3'd1, 12'd2, 0, 0, 0, 0), 0, 2'd0, 1, 11'd9, 0, 0, "R4");
        step(mk(3'd1, 12'd0, 0, 0, 0, 0), 0, 2'd0, 0, 11'd64, 0, 0, "R4");
        step(mk(3'd1, 12'd0, 0, 0, 0, 0), 0, 2'd0, 1, 11'd1, 0, 0, "R4");
        // R5
        step(mk(3'd1, 12'hFFF, 0, 0, 0, 0), 0, 2'd0, 1, 11'd1024, 0, 0, "R5");
        step(mk(3'd1, 12'hFFE, 0, 0, 0, 0), 0, 2'd0, 1, 11'd1024, 0, 0, "R5");
        // R6
        step(mk(0, 0, 3'd1, 3'd7, 0, 0), 0, 2'd1, 1, 11'd64, 0, 0, "R6");
        step(mk(0, 0, 0, 0, 3'd7, 12'hFFF), 0, 2'd2, 1, 11'd1000, 0, 0, "R6");
        // R7
        step(mk(0, 0, 3'd1, 3'd6, 0, 0), 0, 2'd1, 1, 11'd28, 0, 0, "R7");
        step(mk(0, 0, 3'd1, 3'd6, 0, 0), 1, 2'd1, 1, 11'd28, 0, 0, "R7");
        step(mk(0, 0, 3'd1, 3'd6, 0, 0), 0, 2'd1, 1, 11'd24, 0, 0, "R7");
        // R8
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd1, 0, 0, 0, 0, "R8");
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd1, 0, 0, 0, 1, "R8");
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd1, 0, 0, 0, 0, "R8");
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd0, 0, 0, 1, 0, "R8");
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd1, 0, 0, 1, 0, "R8");
        step(mk(0, 0, 0, 3'd7, 0, 0), 0, 2'd1, 0, 0, 0, 0, "R8");
        // R9
        step('1, 1, 2'd3, 0, 0, 0, 0, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [35:0] w;
            logic [10:0] len;
            w = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) w[14:3]  = 12'hFFF;
            if ($urandom_range(0, 3) == 0) w[35:24] = 12'hFFF;
            if ($urandom_range(0, 3) == 0) w[2:0]   = 3'd0;
            if ($urandom_range(0, 1) == 0) w[35:24] = 12'($urandom_range(0, 300));
            if ($urandom_range(0, 1) == 0) w[14:3]  = 12'($urandom_range(0, 300));
            len = 11'($urandom_range(0, 1024));
            step(w, 1'($urandom), 2'($urandom), 1'($urandom), len,
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "R2 R4 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule